// File: doc/BRIEF.md
# Training Sequence Transmit Lane Multiplexer

This block sits on the transmit side of a multi-lane PCI Express physical layer, between the data link layer and the symbol encoder. It builds one common 16-symbol TS1 or TS2 training ordered set and places it on every lane. When no set is being sent, each lane forwards its own data-link-layer symbol. Each output symbol is eight data bits plus a control flag.

A shared sequencer counts through the set and samples the set's contents when the set begins. The training controller supplies a request strobe, the set kind, a global pad flag and the field values. A per-lane stage then personalises the two numbering fields. It writes the lane's own index and the link number into them, or it writes PAD when the controller pads every lane or has switched off this lane. Once a set starts it always runs to its sixteenth symbol. A request that arrives during a set is held and starts a further set straight after the current one.

Top module: `ts_lane_mux`

## Requirements
- R1: While `rst` is high at a clock edge, every lane output after that edge is data 0x00 with the control flag 0, and `os_active` is 0.
- R2: When no set is in progress, lane i outputs the `dl_data`/`dl_k` symbol it was given at the previous clock edge.
- R3: A set is 16 consecutive symbols. Position 0 is COM (0xBC, flag 1). Positions 1 to 5 are link number, lane number, fast-training count, rate and training control. Positions 6 to 15 are the identifier: 0x4A when `ts_kind`=0 (TS1) and 0x45 when `ts_kind`=1 (TS2). All positions other than COM and PAD have flag 0.
- R4: All lanes carry identical symbols at every position of a set except positions 1 and 2.
- R5: Without padding, position 1 carries the captured `link_num` and position 2 carries the lane's index (lane 0 gives 0x00, lane 1 gives 0x01, and so on).
- R6: When `ts_pad` was 1 at the start of a set, positions 1 and 2 on every lane are PAD (0xF7, flag 1).
- R7: When `lane_off[i]` is 1 at the edge that produces position 1 or 2, lane i carries PAD at that position. Other lanes are not affected.
- R8: Once a set has started it completes all 16 symbols whatever `ts_req` does. Data-link symbols are not forwarded during the set.
- R9: A request seen during positions 0 to 14 of a set starts exactly one further set directly after position 15. A request that is held high gives back-to-back sets.
- R10: When idle, a request sampled at edge N gives COM at the output after edge N+1. Kind, pad flag and field values are captured at the edge where a set starts. Changes to them during the set have no effect.
- R11: `os_active` is 1 exactly while the outputs carry set symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_req | input | 1 | Request for a training set |
| ts_kind | input | 1 | 0 = TS1, 1 = TS2 |
| ts_pad | input | 1 | Pad the numbering fields on all lanes |
| link_num | input | 8 | Link number for position 1 |
| nfts | input | 8 | Fast-training sequence count |
| data_rate | input | 8 | Rate identifier symbol |
| train_ctl | input | 8 | Training control symbol |
| lane_off | input | LANES | Per-lane switch-off: force PAD in the numbering fields |
| dl_data | input | 8*LANES | Data-link symbols, lane i at bits [8i+7:8i] |
| dl_k | input | LANES | Data-link control flags |
| tx_data | output | 8*LANES | Output symbols, lane i at bits [8i+7:8i] |
| tx_k | output | LANES | Output control flags |
| os_active | output | 1 | Output holds training-set symbols |

## Verification
The hardest case to reach is the request boundary around the last symbol of a set. A request seen at position 15 must start the next set at once. A request seen earlier must be held for exactly one further set. Several requests during one set must still give only one extra set. The stimulus places single-cycle request pulses at chosen offsets inside a running set, including at its last symbol. It also holds the request high for many cycles. Lane switch-off bits and field values are changed in the middle of sets, so the live sampling of one and the captured sampling of the other are both exercised.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int SYM_W   = 8;
  localparam int SET_LEN = 16;
  localparam int IDX_W   = $clog2(SET_LEN);

  localparam logic [SYM_W-1:0] SYM_COM = 8'hBC;
  localparam logic [SYM_W-1:0] SYM_PAD = 8'hF7;
  localparam logic [SYM_W-1:0] ID_TS1  = 8'h4A;
  localparam logic [SYM_W-1:0] ID_TS2  = 8'h45;

  localparam logic [IDX_W-1:0] POS_COM  = 4'd0;
  localparam logic [IDX_W-1:0] POS_LINK = 4'd1;
  localparam logic [IDX_W-1:0] POS_LANE = 4'd2;
  localparam logic [IDX_W-1:0] POS_NFTS = 4'd3;
  localparam logic [IDX_W-1:0] POS_RATE = 4'd4;
  localparam logic [IDX_W-1:0] POS_CTL  = 4'd5;
  localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(SET_LEN - 1);

  typedef enum logic [1:0] {FLD_FIXED, FLD_LINK, FLD_LANE} fld_e;

  typedef struct packed {
    logic [SYM_W-1:0] data;
    logic             k;
    fld_e             fld;
  } csym_t;

  typedef struct packed {
    logic             kind;
    logic             pad;
    logic [SYM_W-1:0] link;
    logic [SYM_W-1:0] nfts;
    logic [SYM_W-1:0] rate;
    logic [SYM_W-1:0] tctl;
  } ctx_t;
endpackage

// File: rtl/ts_seq.sv
module ts_seq
  import ts_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  ctx_t             ctx_in,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output ctx_t             ctx
);
  logic pend;
  logic at_end;

  assign at_end = !active || (idx == POS_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      pend   <= 1'b0;
      ctx    <= '0;
    end else if (at_end) begin
      if (pend || req) begin
        active <= 1'b1;
        idx    <= '0;
        pend   <= 1'b0;
        ctx    <= ctx_in;
      end else begin
        active <= 1'b0;
      end
    end else begin
      idx <= idx + 1'b1;
      if (req) pend <= 1'b1;
    end
  end

  AST_SET_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    (active && idx != POS_LAST) |=> active); // R8
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (rst)
    (active && idx == POS_LAST && pend) |=> (active && idx == '0)); // R9
  AST_CTX_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && idx != POS_LAST) |=> $stable(ctx)); // R10
endmodule

// File: rtl/ts_sym_build.sv
module ts_sym_build
  import ts_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  ctx_t             ctx,
  output csym_t            sym
);
  always_comb begin
    sym.k    = 1'b0;
    sym.fld  = FLD_FIXED;
    sym.data = ctx.kind ? ID_TS2 : ID_TS1;
    case (idx)
      POS_COM:  begin sym.data = SYM_COM; sym.k = 1'b1; end
      POS_LINK: begin sym.data = ctx.link; sym.fld = FLD_LINK; end
      POS_LANE: begin sym.data = '0; sym.fld = FLD_LANE; end
      POS_NFTS: sym.data = ctx.nfts;
      POS_RATE: sym.data = ctx.rate;
      POS_CTL:  sym.data = ctx.tctl;
      default:  ;
    endcase
  end
endmodule

// File: rtl/ts_lane_stage.sv
module ts_lane_stage
  import ts_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             os_in,
  input  csym_t            sym,
  input  logic             pad_all,
  input  logic             off,
  input  logic [SYM_W-1:0] dl_d,
  input  logic             dl_kf,
  output logic [SYM_W-1:0] out_d,
  output logic             out_k
);
  localparam logic [SYM_W-1:0] MY_NUM = SYM_W'(LANE_ID);

  logic force_pad;
  assign force_pad = pad_all || off;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_d <= '0;
      out_k <= 1'b0;
    end else if (os_in) begin
      case (sym.fld)
        FLD_LINK: begin
          out_d <= force_pad ? SYM_PAD : sym.data;
          out_k <= force_pad;
        end
        FLD_LANE: begin
          out_d <= force_pad ? SYM_PAD : MY_NUM;
          out_k <= force_pad;
        end
        default: begin
          out_d <= sym.data;
          out_k <= sym.k;
        end
      endcase
    end else begin
      out_d <= dl_d;
      out_k <= dl_kf;
    end
  end

  AST_OFF_PADS: assert property (@(posedge clk) disable iff (rst)
    (os_in && sym.fld != FLD_FIXED && off) |=> (out_k && out_d == SYM_PAD)); // R7
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
    !os_in |=> (out_d == $past(dl_d) && out_k == $past(dl_kf))); // R2
endmodule

// File: rtl/ts_lane_mux.sv
module ts_lane_mux
  import ts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ts_req,
  input  logic                   ts_kind,
  input  logic                   ts_pad,
  input  logic [7:0]             link_num,
  input  logic [7:0]             nfts,
  input  logic [7:0]             data_rate,
  input  logic [7:0]             train_ctl,
  input  logic [LANES-1:0]       lane_off,
  input  logic [LANES*8-1:0]     dl_data,
  input  logic [LANES-1:0]       dl_k,
  output logic [LANES*8-1:0]     tx_data,
  output logic [LANES-1:0]       tx_k,
  output logic                   os_active
);
  ctx_t             ctx_in, ctx;
  logic             active;
  logic [IDX_W-1:0] idx;
  csym_t            sym;

  always_comb begin
    ctx_in.kind = ts_kind;
    ctx_in.pad  = ts_pad;
    ctx_in.link = link_num;
    ctx_in.nfts = nfts;
    ctx_in.rate = data_rate;
    ctx_in.tctl = train_ctl;
  end

  ts_seq seq_i (
    .clk(clk), .rst(rst), .req(ts_req), .ctx_in(ctx_in),
    .active(active), .idx(idx), .ctx(ctx)
  );

  ts_sym_build build_i (.idx(idx), .ctx(ctx), .sym(sym));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ts_lane_stage #(.LANE_ID(g)) stage_i (
      .clk(clk), .rst(rst), .os_in(active), .sym(sym),
      .pad_all(ctx.pad), .off(lane_off[g]),
      .dl_d(dl_data[g*SYM_W +: SYM_W]), .dl_kf(dl_k[g]),
      .out_d(tx_data[g*SYM_W +: SYM_W]), .out_k(tx_k[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) os_active <= 1'b0;
    else     os_active <= active;
  end

  AST_COM_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(os_active) |-> (tx_k[0] && tx_data[7:0] == SYM_COM)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!os_active && tx_k == '0 && tx_data == '0)); // R1
endmodule

// File: tb/ts_lane_mux_tb.sv
module ts_lane_mux_tb_top;
  localparam int L = 4;

  logic clk = 0, rst = 1;
  logic ts_req = 0, ts_kind = 0, ts_pad = 0;
  logic [7:0] link_num = 0, nfts = 0, data_rate = 0, train_ctl = 0;
  logic [L-1:0] lane_off = 0;
  logic [L*8-1:0] dl_data = 0;
  logic [L-1:0] dl_k = 0;
  logic [L*8-1:0] tx_data;
  logic [L-1:0] tx_k;
  logic os_active;

  int checks = 0, fails = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  ts_lane_mux #(.LANES(L)) dut_i (
    .clk(clk), .rst(rst), .ts_req(ts_req), .ts_kind(ts_kind), .ts_pad(ts_pad),
    .link_num(link_num), .nfts(nfts), .data_rate(data_rate), .train_ctl(train_ctl),
    .lane_off(lane_off), .dl_data(dl_data), .dl_k(dl_k),
    .tx_data(tx_data), .tx_k(tx_k), .os_active(os_active)
  );

  // behavioural reference
  int m_act = 0, m_idx = 0, m_pend = 0;
  int c_kind = 0, c_pad = 0;
  int c_link = 0, c_nfts = 0, c_rate = 0, c_ctl = 0;
  logic [7:0] e_d [L];
  logic       e_k [L];
  logic       e_os = 0;
  int         e_pos = -1;

  initial for (int l = 0; l < L; l++) begin e_d[l] = 0; e_k[l] = 0; end

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_idx = 0; m_pend = 0;
      e_os = 0; e_pos = -1;
      for (int l = 0; l < L; l++) begin e_d[l] = 0; e_k[l] = 0; end
    end else begin
      e_os  = (m_act != 0);
      e_pos = m_act ? m_idx : -1;
      for (int l = 0; l < L; l++) begin
        if (!m_act) begin
          e_d[l] = dl_data[l*8 +: 8]; e_k[l] = dl_k[l];
        end else if (m_idx == 0) begin
          e_d[l] = 8'hBC; e_k[l] = 1;
        end else if (m_idx == 1 || m_idx == 2) begin
          if (c_pad != 0 || lane_off[l]) begin e_d[l] = 8'hF7; e_k[l] = 1; end
          else begin e_d[l] = (m_idx == 1) ? 8'(c_link) : 8'(l); e_k[l] = 0; end
        end else begin
          e_k[l] = 0;
          case (m_idx)
            3: e_d[l] = 8'(c_nfts);
            4: e_d[l] = 8'(c_rate);
            5: e_d[l] = 8'(c_ctl);
            default: e_d[l] = c_kind ? 8'h45 : 8'h4A;
          endcase
        end
      end
      if (!m_act || m_idx == 15) begin
        if (m_pend || ts_req) begin
          m_act = 1; m_idx = 0; m_pend = 0;
          c_kind = ts_kind; c_pad = ts_pad; c_link = link_num;
          c_nfts = nfts; c_rate = data_rate; c_ctl = train_ctl;
        end else m_act = 0;
      end else begin
        m_idx++;
        if (ts_req) m_pend = 1;
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    for (int l = 0; l < L; l++) begin
      checks++;
      if (tx_data[l*8 +: 8] !== e_d[l] || tx_k[l] !== e_k[l]) begin
        fails++;
        $display("FAIL %s (pos %0d) lane %0d: got %h/%b expected %h/%b",
                 tag, e_pos, l, tx_data[l*8 +: 8], tx_k[l], e_d[l], e_k[l]);
      end
    end
    checks++;
    if (os_active !== e_os) begin
      fails++;
      $display("FAIL R11 os_active: got %b expected %b", os_active, e_os);
    end
    if (os_active === 1'b1 && e_pos != 1 && e_pos != 2) begin
      for (int l = 1; l < L; l++) begin
        checks++;
        if (tx_data[l*8 +: 8] !== tx_data[7:0] || tx_k[l] !== tx_k[0]) begin
          fails++;
          $display("FAIL R4 lane %0d differs: got %h expected %h",
                   l, tx_data[l*8 +: 8], tx_data[7:0]);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) begin
      @(negedge clk);
      for (int l = 0; l < L; l++) dl_data[l*8 +: 8] = 8'($urandom);
      dl_k = L'($urandom);
    end
  endtask

  task automatic pulse();
    @(negedge clk); ts_req = 1;
    @(negedge clk); ts_req = 0;
  endtask

  initial begin
    cyc(3);
    @(negedge clk); rst = 0;
    tag = "R2"; cyc(20);
    tag = "R3"; link_num = 8'h11; nfts = 8'h20; data_rate = 8'h02; train_ctl = 8'h00;
    pulse(); cyc(20);
    tag = "R5"; link_num = 8'h5A; ts_kind = 1; pulse(); cyc(18);
    tag = "R10"; ts_kind = 0; link_num = 8'h33; pulse();
    cyc(4); ts_kind = 1; link_num = 8'h99; nfts = 8'hFF; train_ctl = 8'h0F; ts_pad = 1;
    cyc(16); ts_pad = 0;
    tag = "R6"; ts_pad = 1; ts_kind = 1; pulse(); ts_pad = 0; cyc(18);
    tag = "R7"; lane_off = 4'b0101; pulse(); cyc(18);
    lane_off = 4'b0000; pulse(); lane_off = 4'b1000; cyc(1); lane_off = 4'b0010; cyc(18);
    lane_off = 0;
    tag = "R9"; pulse(); cyc(5); pulse(); pulse(); cyc(40);
    pulse(); cyc(13); pulse(); cyc(40);
    tag = "R8"; @(negedge clk); ts_req = 1; cyc(40); ts_req = 0; cyc(40);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule